// File: doc/BRIEF.md
# Sized-Access Memory Port with Container Alignment

This block is a shared memory made of 32-bit containers that is addressed by byte. Each request carries a size code (byte, 16-bit half or 32-bit full) and a byte address. The two low address bits choose a byte lane inside a container, and the upper bits choose the container. A wide access is never split across two containers and never raises an error. A half access drops address bit 0, and a full access drops address bits 1:0. The access then lands on its natural boundary inside the container that holds the addressed byte.

Reads return the selected lane shifted down to bit 0, with zeros in the bits above it. Writes copy the low-order bits of the write data into every lane. A per-byte enable then lets only the selected bytes change. Software that issues a 32-bit access at an address not divisible by four therefore reaches the aligned container, not the bytes it named. This block reproduces that effect exactly.

There is a single synchronous request port. A read result comes back one clock after the request, together with a one-cycle valid strobe.

Top module: `sized_mem_port`

## Requirements
- R1: While reset is low and on the first cycle after it, `rsp_valid` is 0 and `rsp_data` is 0.
- R2: Size codes on `req_size` are: 2'b00 byte, 2'b01 half, 2'b10 full. Code 2'b11 behaves exactly like 2'b10.
- R3: A full access ignores `req_addr[1:0]`. It reads or writes all four bytes of the container.
- R4: A half access ignores `req_addr[0]`. When `req_addr[1]` is 0 it uses container bits 15:0, and when `req_addr[1]` is 1 it uses bits 31:16.
- R5: A byte access uses lane k = `req_addr[1:0]`, which is container bits 8k+7:8k (lane 0 is the least significant).
- R6: Byte reads return zeros in `rsp_data[31:8]`, and half reads return zeros in `rsp_data[31:16]`.
- R7: A write changes only the bytes of the selected lane(s). It stores `req_wdata[7:0]` for a byte, `req_wdata[15:0]` for a half and `req_wdata[31:0]` for a full access. All other bytes of that container and of every other container are left unchanged.
- R8: `rsp_valid` is 1 exactly one clock after a read is accepted (`req_valid`=1, `req_we`=0), and 0 after a write or an idle cycle. `rsp_data` holds its last value whenever `rsp_valid` is 0.
- R9: A read issued in the cycle right after a write to the same container returns the newly written data.
- R10: The container index is `req_addr[2+IDX_W-1:2]`, where IDX_W = log2(WORDS) and WORDS defaults to 256. Higher address bits are ignored, so addresses 1024 bytes apart alias.
- R11: A full write at byte address 4k+m with m≠0 updates container k. A full read at 4k+m returns container k, and container k+1 is not modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Write data, low-order bits used for narrow sizes |
| rsp_data | output | 32 | Read result, zero-extended |
| rsp_valid | output | 1 | One-cycle strobe marking a read result |

## Verification
The case that is hardest to reach from the ports is a misaligned full write followed by reads of its neighbour. The damage is silent: the write lands in the aligned container, and the neighbour shows nothing unless it was given known contents first. The bench therefore fills containers with distinct patterns, then issues full and half writes at every misaligned offset. It follows each with aligned byte reads of both the target and the following container, all compared against a byte-array model that applies the same clearing of low address bits. A write followed directly by a read of the same container is covered by issuing the two requests on consecutive cycles.

// File: rtl/smp_pkg.sv
// Shared definitions for the sized-access memory port.
// Assumes 32-bit containers made of four byte lanes.
package smp_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_FULL = 2'b10,
        SZ_WIDE = 2'b11   // treated the same as SZ_FULL (R2)
    } size_e;

    // True when the size code selects a full container access (R2, R3)
    function automatic logic is_full(input logic [1:0] sz);
        return sz[1];
    endfunction
endpackage

// File: rtl/smp_lane_ctrl.sv
// Turns size and low address bits into an aligned lane, byte enables and
// replicated write data. Purely combinational.
// Assumes NBYTES = 4 lanes per container.
module smp_lane_ctrl #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int LANE_W = $clog2(NBYTES)
) (
    input  logic [1:0]        size,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANE_W-1:0] eff_lane,
    output logic [NBYTES-1:0] be,
    output logic [DATA_W-1:0] wlanes
);
    import smp_pkg::*;

    // Align the lane and build enables and replicated data per size
    always_comb begin
        if (is_full(size)) begin
            eff_lane = '0;
            be       = '1;
            wlanes   = wdata;
        end else if (size == SZ_HALF) begin
            eff_lane = {lane[LANE_W-1], 1'b0};
            be       = NBYTES'(2'b11) << eff_lane;
            wlanes   = {(DATA_W/16){wdata[15:0]}};
        end else begin
            eff_lane = lane;
            be       = NBYTES'(1'b1) << eff_lane;
            wlanes   = {NBYTES{wdata[7:0]}};
        end
    end
endmodule

// File: rtl/smp_store.sv
// Container storage with per-byte write enables and a registered read port.
// Assumes only one of read or write per cycle. The array has no reset;
// the read register does.
module smp_store #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 256,
    localparam int NBYTES = DATA_W / 8,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [NBYTES-1:0] be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [7:0] mem [WORDS];
        logic [7:0] q;

        // Write this lane when its enable is set
        always_ff @(posedge clk) begin
            if (we && be[b]) mem[idx] <= wdata[8*b +: 8];
        end

        // Capture this lane on a read; clear it on reset
        always_ff @(posedge clk) begin
            if (!rst_n)  q <= '0;
            else if (re) q <= mem[idx];
        end

        assign rdata[8*b +: 8] = q;
    end
endmodule

// File: rtl/smp_rd_align.sv
// Remembers the size and lane of a read, then shifts the returned
// container down and zero-extends it. Also raises the valid strobe.
// Assumes raw data is valid the cycle after capture.
module smp_rd_align #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int LANE_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [1:0]        size,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] data,
    output logic              valid
);
    import smp_pkg::*;

    logic [1:0]        size_q;
    logic [LANE_W-1:0] lane_q;
    logic [DATA_W-1:0] shifted;

    // Hold the format of the last read and pulse valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= SZ_FULL;
            lane_q <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) begin
                size_q <= size;
                lane_q <= lane;
            end
        end
    end

    // Shift the chosen lane down to bit 0 and clear the bits above it
    always_comb begin
        shifted = raw >> {lane_q, 3'b000};
        if (is_full(size_q))      data = raw;
        else if (size_q == SZ_HALF) data = {{(DATA_W-16){1'b0}}, shifted[15:0]};
        else                        data = {{(DATA_W-8){1'b0}}, shifted[7:0]};
    end
endmodule

// File: rtl/sized_mem_port.sv
// Byte-addressed memory of 32-bit containers with byte, half and full
// accesses. Wide accesses are realigned by dropping low address bits.
// Assumes one request per cycle and no arbitration in front.
module sized_mem_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int WORDS  = 256,
    localparam int NBYTES = DATA_W / 8,
    localparam int LANE_W = $clog2(NBYTES),
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_valid
);
    logic [LANE_W-1:0] eff_lane;
    logic [NBYTES-1:0] be;
    logic [DATA_W-1:0] wlanes;
    logic [DATA_W-1:0] raw;
    logic [IDX_W-1:0]  idx;
    logic              do_wr;
    logic              do_rd;

    // Decode the request into a write strobe, read strobe and container index
    always_comb begin
        do_wr = req_valid && req_we;
        do_rd = req_valid && !req_we;
        idx   = req_addr[LANE_W +: IDX_W];
    end

    smp_lane_ctrl #(.DATA_W(DATA_W)) u_lane (
        .size(req_size), .lane(req_addr[LANE_W-1:0]), .wdata(req_wdata),
        .eff_lane(eff_lane), .be(be), .wlanes(wlanes)
    );

    smp_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
        .clk(clk), .rst_n(rst_n), .we(do_wr), .re(do_rd), .idx(idx),
        .be(be), .wdata(wlanes), .rdata(raw)
    );

    smp_rd_align #(.DATA_W(DATA_W)) u_align (
        .clk(clk), .rst_n(rst_n), .capture(do_rd), .size(req_size),
        .lane(eff_lane), .raw(raw), .data(rsp_data), .valid(rsp_valid)
    );

    // R8
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we) |=> rsp_valid);
    // R8
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_we) |=> !rsp_valid);
    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable(rsp_data));
    // R6
    byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_size) == 2'b00) |-> rsp_data[DATA_W-1:8] == '0);
    // R6
    half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_size) == 2'b01) |-> rsp_data[DATA_W-1:16] == '0);
    // R3
    full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size[1]) |-> be == '1);
    // R4
    half_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b01) |-> $countones(be) == 2 && !be[1:0] != !be[3:2]);
endmodule

// File: tb/sized_mem_port_test.sv
module sized_mem_port_test;
    localparam int NREF = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_data;
    logic        rsp_valid;

    int vectors = 0;
    int misses  = 0;
    logic [7:0] refm [NREF];

    always #5 clk = ~clk;

    sized_mem_port uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_data(rsp_data), .rsp_valid(rsp_valid)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int align(input logic [1:0] sz, input logic [15:0] a);
        int x = int'(a) % NREF;
        if (sz[1]) return x & ~3;
        if (sz == 2'b01) return x & ~1;
        return x;
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return sz[1] ? 4 : (sz == 2'b01 ? 2 : 1);
    endfunction

    function automatic logic [31:0] ref_read(input logic [1:0] sz, input logic [15:0] a);
        logic [31:0] v = '0;
        int base = align(sz, a);
        for (int i = 0; i < nbytes(sz); i++) v[8*i +: 8] = refm[base + i];
        return v;
    endfunction

    task automatic do_write(input logic [1:0] sz, input logic [15:0] a, input logic [31:0] d,
                            input string tag);
        int base = align(sz, a);
        req_valid = 1'b1; req_we = 1'b1; req_size = sz; req_addr = a; req_wdata = d;
        for (int i = 0; i < nbytes(sz); i++) refm[base + i] = d[8*i +: 8];
        @(negedge clk);
        req_valid = 1'b0;
        if (tag != "") chk({tag, " valid after write"}, {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic do_read(input logic [1:0] sz, input logic [15:0] a, input string tag);
        req_valid = 1'b1; req_we = 1'b0; req_size = sz; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
        chk({tag, " data"}, rsp_data, ref_read(sz, a));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'd0, rsp_valid}, 32'd0);
        chk("R1 data in reset", rsp_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R1 data after reset", rsp_data, 32'd0);
    endtask

    task automatic t_fill;
        for (int w = 0; w < NREF / 4; w++)
            do_write(2'b10, 16'(4 * w), 32'h5A000000 | 32'(w * 32'h010101), "");
    endtask

    task automatic t_full_misaligned;
        do_read(2'b10, 16'h0040, "R3 aligned full read");
        for (int m = 1; m < 4; m++) do_read(2'b10, 16'(16'h0040 + m), "R3 misaligned full read");
        for (int m = 1; m < 4; m++) begin
            do_write(2'b10, 16'(16'h0080 + 4 * m + m), 32'hC0DE0000 | 32'(m), "R11");
            for (int b = 0; b < 8; b++)
                do_read(2'b00, 16'(16'h0080 + 4 * m + b), "R11 target/neighbour byte");
        end
    endtask

    task automatic t_half;
        do_write(2'b01, 16'h0101, 32'hFFFFBEEF, "R4");
        do_read(2'b01, 16'h0100, "R4 low half");
        do_read(2'b01, 16'h0103, "R4 high half misaligned");
        do_write(2'b01, 16'h0103, 32'h1234CAFE, "R4");
        do_read(2'b10, 16'h0100, "R4 container after half writes");
    endtask

    task automatic t_byte;
        for (int k = 0; k < 4; k++) do_write(2'b00, 16'(16'h0200 + k), 32'hFFFFFF10 + 32'(k), "R7");
        do_read(2'b10, 16'h0200, "R5 lane order");
        for (int k = 0; k < 4; k++) do_read(2'b00, 16'(16'h0200 + k), "R5 byte lane");
        do_read(2'b10, 16'h0204, "R7 next container untouched");
    endtask

    task automatic t_zext;
        do_write(2'b10, 16'h0300, 32'hF1F2F3F4, "R6");
        do_read(2'b00, 16'h0302, "R6 byte zero-extend");
        do_read(2'b01, 16'h0302, "R6 half zero-extend");
    endtask

    task automatic t_size3;
        do_write(2'b11, 16'h0342, 32'hA5B6C7D8, "R2");
        do_read(2'b10, 16'h0340, "R2 code 11 write as full");
        do_read(2'b11, 16'h0343, "R2 code 11 read as full");
    endtask

    task automatic t_raw;
        do_write(2'b10, 16'h0380, 32'h11111111, "R9");
        do_write(2'b00, 16'h0381, 32'h000000EE, "R9");
        do_read(2'b10, 16'h0380, "R9 read right after write");
    endtask

    task automatic t_alias;
        do_write(2'b10, 16'h0404, 32'h0BADF00D, "R10");
        do_read(2'b10, 16'h0004, "R10 aliased container");
        do_read(2'b10, 16'hFC04, "R10 high bits ignored");
    endtask

    task automatic t_hold;
        logic [31:0] last;
        do_read(2'b10, 16'h0010, "R8 read");
        last = rsp_data;
        @(negedge clk);
        chk("R8 idle no valid", {31'd0, rsp_valid}, 32'd0);
        chk("R8 data held", rsp_data, last);
        do_write(2'b10, 16'h0010, 32'h77777777, "R8");
        chk("R8 data held after write", rsp_data, last);
    endtask

    task automatic t_mixed;
        logic [31:0] lf = 32'h1ACE5EED;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            if (lf[3]) do_write(lf[5:4], {6'd0, lf[17:8]}, {lf[15:0], lf[31:16]}, "R7 mixed");
            else       do_read(lf[5:4], {6'd0, lf[17:8]}, "R7 mixed read");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_fill;
        t_full_misaligned;
        t_half;
        t_byte;
        t_zext;
        t_size3;
        t_raw;
        t_alias;
        t_hold;
        t_mixed;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule